// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

This block is a 32-pin general-purpose I/O peripheral seen by a host as a small bank of 32-bit registers. Software never rewrites the whole output word. Instead it writes a mask to one of four strobe registers. These set or clear bits of the output-value latch or of the drive-enable latch in a single atomic access, so code that owns different pins cannot corrupt each other's state. A fifth, read-only register returns the pin levels after they pass through a two-stage synchroniser.

The host port carries a word address, a write strobe, a read strobe and 32-bit data. Every access moves a full little-endian word, and bit n of each register belongs to pin n. The pin side gives each pin a driven value, a drive enable and a sampled input. A pad ring combines these into a tri-state buffer.

Top module: `gpsc_bank`

## Requirements
- R1: While reset is held, and after it is released, the output values are all 0 and the drive enables are all 0, so every pin is an input. The read data is also 0.
- R2: A write to word address 0x00 sets each output-value bit whose write-data bit is 1. The other output-value bits keep their value.
- R3: A write to word address 0x04 clears each output-value bit whose write-data bit is 1. The other output-value bits keep their value.
- R4: A write to word address 0x08 sets the drive-enable bit of each pin whose write-data bit is 1. The other enables keep their value.
- R5: A write to word address 0x0C clears the drive-enable bit of each pin whose write-data bit is 1. The other enables keep their value.
- R6: A read of word address 0x10 returns the pin levels, with bit n being pin n. A change on the pins becomes visible only to a read issued two or more clock edges after the change.
- R7: A read of word address 0x00 or 0x04 returns the output-value latch. A read of 0x08 or 0x0C returns the drive-enable latch.
- R8: A read of any other word address returns 0. A write to any other word address, including the read-only 0x10, changes neither latch.
- R9: A write whose data is all zeros changes neither latch.
- R10: The read data appears on the edge that samples the read strobe. It then holds until the next read.
- R11: A write takes effect on the clock edge that samples the write strobe. Until that edge the outputs keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address of the access |
| wdata | input | 32 | Write data, used as a bit mask |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output value for each pin |
| pin_oe | output | 32 | Drive enable for each pin (1 = driven) |

## Verification
The hardest case to reach from the ports is the synchroniser latency. The read must be shown to return stale levels for exactly two edges after a pin change. The stimulus changes the pins in the same cycle as the first of three back-to-back reads of the level register. The scoreboard then expects old, old, new. The other hard cases are proving that a write left a latch untouched, and that a write had not yet taken effect. For an all-zero mask or a stray address, the bench reads both latches back and watches the pins. Between the driving edge and the sampling edge it confirms the outputs still show the old value.

// File: rtl/gpsc_pkg.sv
package gpsc_pkg;

    // Word addresses of the bank; software depends on these.
    localparam int WA_OUT_SET = 'h00;
    localparam int WA_OUT_CLR = 'h04;
    localparam int WA_OE_SET  = 'h08;
    localparam int WA_OE_CLR  = 'h0C;
    localparam int WA_PIN_LVL = 'h10;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_OUT_SET = 3'd1,
        SEL_OUT_CLR = 3'd2,
        SEL_OE_SET  = 3'd3,
        SEL_OE_CLR  = 3'd4,
        SEL_PIN_LVL = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/gpsc_sync.sv
module gpsc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q[LAST];

endmodule

// File: rtl/gpsc_decode.sv
module gpsc_decode
    import gpsc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          wr_sel,
    output reg_sel_e          rd_sel
);
    reg_sel_e hit;

    always_comb begin
        hit = SEL_NONE;
        if (addr == ADDR_W'(WA_OUT_SET)) hit = SEL_OUT_SET;
        if (addr == ADDR_W'(WA_OUT_CLR)) hit = SEL_OUT_CLR;
        if (addr == ADDR_W'(WA_OE_SET))  hit = SEL_OE_SET;
        if (addr == ADDR_W'(WA_OE_CLR))  hit = SEL_OE_CLR;
        if (addr == ADDR_W'(WA_PIN_LVL)) hit = SEL_PIN_LVL;
    end

    always_comb begin
        wr_sel = SEL_NONE;
        // The level register is read-only: a write there is dropped.
        if (wr_en && hit != SEL_PIN_LVL) wr_sel = hit;
        rd_sel = rd_en ? hit : SEL_NONE;
    end

endmodule

// File: rtl/gpsc_latch.sv
module gpsc_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (set_stb) q_d = q_q | mask;
        else if (clr_stb) q_d = q_q & ~mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;

endmodule

// File: rtl/gpsc_bank.sv
module gpsc_bank
    import gpsc_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    typedef struct packed {
        logic [NUM_PINS-1:0] rdata;
    } bank_st_t;

    reg_sel_e            wr_sel, rd_sel;
    logic [NUM_PINS-1:0] lvl_sync;
    bank_st_t            st_d, st_q;

    gpsc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    gpsc_latch #(.W(NUM_PINS)) u_out_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_sel == SEL_OUT_SET),
        .clr_stb (wr_sel == SEL_OUT_CLR),
        .mask    (wdata),
        .q       (pin_out)
    );

    gpsc_latch #(.W(NUM_PINS)) u_oe_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_sel == SEL_OE_SET),
        .clr_stb (wr_sel == SEL_OE_CLR),
        .mask    (wdata),
        .q       (pin_oe)
    );

    gpsc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl_sync)
    );

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            unique case (rd_sel)
                SEL_OUT_SET, SEL_OUT_CLR: st_d.rdata = pin_out;
                SEL_OE_SET,  SEL_OE_CLR:  st_d.rdata = pin_oe;
                SEL_PIN_LVL:              st_d.rdata = lvl_sync;
                default:                  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/gpsc_bank_chk.sv
module gpsc_bank_chk
    import gpsc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [NUM_PINS-1:0] wdata,
    input logic [NUM_PINS-1:0] rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);
    logic a_os, a_oc, a_es, a_ec, a_unm;
    assign a_os  = addr == ADDR_W'(WA_OUT_SET);
    assign a_oc  = addr == ADDR_W'(WA_OUT_CLR);
    assign a_es  = addr == ADDR_W'(WA_OE_SET);
    assign a_ec  = addr == ADDR_W'(WA_OE_CLR);
    assign a_unm = !(a_os || a_oc || a_es || a_ec || addr == ADDR_W'(WA_PIN_LVL));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (pin_out == '0 && pin_oe == '0 && rdata == '0)
                else $error("R1 outputs not idle in reset");
        end
    end

    a_r2_out_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_os) |=> pin_out == ($past(pin_out) | $past(wdata)));
    a_r3_out_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_oc) |=> pin_out == ($past(pin_out) & ~$past(wdata)));
    a_r4_oe_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_es) |=> pin_oe == ($past(pin_oe) | $past(wdata)));
    a_r5_oe_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_ec) |=> pin_oe == ($past(pin_oe) & ~$past(wdata)));
    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && a_unm) |=> rdata == '0);
    a_r8_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (a_os || a_oc)) |=> $stable(pin_out));
    a_r8_r11_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (a_es || a_ec)) |=> $stable(pin_oe));
    a_r9_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == '0) |=> ($stable(pin_out) && $stable(pin_oe)));
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind gpsc_bank gpsc_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpsc_bank_bench.sv
module gpsc_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_out = '0;
    logic [31:0] exp_oe  = '0;
    logic [31:0] last_rd = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    always #2.5 clk = ~clk;

    gpsc_bank u_gpsc_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Monitor: a read sampled on an edge is compared at the following falling edge.
    always @(posedge clk) rd_pend <= rd_en && rst_n;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", rdata, 32'hx);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
                last_rd = rdata;
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        case (a)
            5'h00: exp_out = exp_out | d;
            5'h04: exp_out = exp_out & ~d;
            5'h08: exp_oe  = exp_oe | d;
            5'h0C: exp_oe  = exp_oe & ~d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pin_out in reset", pin_out, 32'h0);
        check("R1 pin_oe in reset", pin_oe, 32'h0);
        check("R1 rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;
        idle();
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        rd(5'h10, 32'h0, "R1 levels after reset");

        // R2 and R11: old value seen before the edge, new after it
        wr(5'h00, 32'h0000_00F0);
        #1 check("R11 pin_out before edge", pin_out, 32'h0);
        idle();
        check("R2 set bits", pin_out, exp_out);
        wr(5'h00, 32'h8000_0001);
        idle();
        check("R2 set keeps others", pin_out, 32'h8000_00F1);
        wr(5'h04, 32'h0000_0030);
        idle();
        check("R3 clear bits", pin_out, 32'h8000_00C1);
        wr(5'h08, 32'hFFFF_0000);
        #1 check("R11 pin_oe before edge", pin_oe, 32'h0);
        idle();
        check("R4 oe set", pin_oe, 32'hFFFF_0000);
        wr(5'h0C, 32'h0F00_0000);
        idle();
        check("R5 oe clear", pin_oe, 32'hF0FF_0000);
        check("R5 pin_out untouched by oe write", pin_out, exp_out);

        // R7 readback
        rd(5'h00, 32'h8000_00C1, "R7 read 0x00");
        rd(5'h04, 32'h8000_00C1, "R7 read 0x04");
        rd(5'h08, 32'hF0FF_0000, "R7 read 0x08");
        rd(5'h0C, 32'hF0FF_0000, "R7 read 0x0C");
        idle();

        // R9 zero-mask writes
        wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h08, 32'h0); wr(5'h0C, 32'h0);
        idle();
        check("R9 pin_out after zero writes", pin_out, 32'h8000_00C1);
        check("R9 pin_oe after zero writes", pin_oe, 32'hF0FF_0000);

        // R8 stray writes and reads
        wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h01, 32'hFFFF_FFFF); wr(5'h1F, 32'hFFFF_FFFF);
        idle();
        check("R8 pin_out after stray writes", pin_out, exp_out);
        check("R8 pin_oe after stray writes", pin_oe, exp_oe);
        rd(5'h14, 32'h0, "R8 read 0x14");
        rd(5'h01, 32'h0, "R8 read 0x01");
        rd(5'h1F, 32'h0, "R8 read 0x1F");
        rd(5'h00, exp_out, "R8 latch after stray writes");

        // R6 synchroniser latency: old, old, new
        @(negedge clk);
        pin_in = 32'hA5A5_1234;
        wr_en = 1'b0; rd_en = 1'b1; addr = 5'h10;
        exp_q.push_back(32'h0); tag_q.push_back("R6 first read stale");
        rd(5'h10, 32'h0, "R6 second read stale");
        rd(5'h10, 32'hA5A5_1234, "R6 third read fresh");
        idle();

        // R10 hold without reads
        pin_in = 32'h0000_FFFF;
        repeat (4) idle();
        check("R10 rdata held", rdata, 32'hA5A5_1234);
        rd(5'h10, 32'h0000_FFFF, "R6 new levels");
        idle();

        // Clear everything
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        idle();
        check("R3 clear all", pin_out, 32'h0);
        check("R5 clear all", pin_oe, 32'h0);
        repeat (2) idle();
        check("R10 last read value held", rdata, last_rd);
        check("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule